// File: doc/BRIEF.md
# Chainable Binary Up/Down Counter

A synchronous binary counter built from 4-bit slices that count up or down on the rising clock edge. A master clear, active high, forces the count to zero at once, without waiting for a clock edge, and overrides every other input. A parallel-load input, active high, makes the count output follow the data inputs continuously while it is held high, whatever the clock, enable and direction are doing. Counting happens only when clear and load are low and the active-low enable is low.

Each slice drives an active-low terminal-count flag that is combinational in the slice's count, the direction and the slice's enable. It goes low at the top of the range (all ones) when counting up, and at the bottom (all zeros) when counting down. The flag of each slice is the enable of the next slice, so a chain of `STAGES` slices behaves as one wide up/down counter with no carry logic between the slices. The flag of the last slice is brought out, so that whole chains can be cascaded in the same way.

Top module: `updn_chain`

## Requirements
- R1: While `clr_i` is 1, `count_o` is 0 with no clock edge needed, whatever `load_i`, `data_i`, `en_n_i` and `up_i` are.
- R2: While `load_i` is 1 and `clr_i` is 0, `count_o` equals `data_i` with no clock edge needed, and it follows every change on `data_i`.
- R3: After `load_i` falls, `count_o` holds the value `data_i` had at the last rising clock edge with `load_i` high. Load must stay high across at least one rising edge.
- R4: With `en_n_i` = 1, rising clock edges leave `count_o` unchanged.
- R5: With `up_i` = 1 and `en_n_i` = 0, each rising edge adds 1 to `count_o` modulo 2^(4*STAGES). The largest value wraps to 0.
- R6: With `up_i` = 0 and `en_n_i` = 0, each rising edge subtracts 1 modulo 2^(4*STAGES). Zero wraps to all ones. The direction may change at any edge.
- R7: With `up_i` = 1, `tc_n_o` is 0 exactly when `en_n_i` = 0 and `count_o` is all ones.
- R8: With `up_i` = 0, `tc_n_o` is 0 exactly when `en_n_i` = 0 and `count_o` is zero. `tc_n_o` follows changes on `en_n_i` and `up_i` without a clock edge.
- R9: A carry or borrow passes between slices in the same edge: 0x0F counts up to 0x10, and 0x10 counts down to 0x0F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| clr_i | input | 1 | Master clear, active high, asynchronous |
| load_i | input | 1 | Parallel load, active high, level sensitive |
| up_i | input | 1 | Direction: 1 counts up, 0 counts down |
| en_n_i | input | 1 | Count enable of the first slice, active low |
| data_i | input | 4*STAGES | Parallel load value |
| count_o | output | 4*STAGES | Current count |
| tc_n_o | output | 1 | Terminal count of the last slice, active low |

## Verification
Clear, load and the terminal-count flag act combinationally. The bench checks them a nanosecond after it changes the input, with no clock edge in between. A count step lands on the first rising edge after the inputs are set. The bench drives all inputs on the falling edge and samples on the next falling edge, so each check sees exactly one register update. Each load is held high across one rising edge before it is released, and the held value is then compared with the data present at that edge.

// File: rtl/updn_pkg.sv
package updn_pkg;

    parameter int SLICE_W = 4;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    typedef logic [SLICE_W-1:0] slice_t;

    // Value one step away in the chosen direction, wrapping at the slice edges.
    function automatic slice_t step_value(input slice_t v, input dir_e d);
        return (d == DIR_UP) ? slice_t'(v + 1'b1) : slice_t'(v - 1'b1);
    endfunction

    // Last value before a wrap in the chosen direction.
    function automatic logic at_end(input slice_t v, input dir_e d);
        return (d == DIR_UP) ? (v == '1) : (v == '0);
    endfunction

endpackage

// File: rtl/updn_term.sv
module updn_term
    import updn_pkg::*;
(
    input  slice_t value_i,
    input  dir_e   dir_i,
    input  logic   en_n_i,
    output logic   tc_n_o
);
    always_comb begin
        tc_n_o = ~(~en_n_i & at_end(value_i, dir_i));
    end
endmodule

// File: rtl/updn_slice.sv
module updn_slice
    import updn_pkg::*;
(
    input  logic   clk,
    input  logic   clr_i,
    input  logic   load_i,
    input  dir_e   dir_i,
    input  logic   en_n_i,
    input  slice_t data_i,
    output slice_t count_o,
    output logic   tc_n_o
);
    slice_t state_q;
    slice_t view;

    // Clear acts at once. Load is captured at every edge while it is high.
    always_ff @(posedge clk or posedge clr_i) begin
        if (clr_i) begin
            state_q <= '0;
        end else if (load_i) begin
            state_q <= data_i;
        end else if (!en_n_i) begin
            state_q <= step_value(state_q, dir_i);
        end
    end

    // A high load shows the data at once. A high clear has already zeroed the state.
    always_comb begin
        if (clr_i)       view = '0;
        else if (load_i) view = data_i;
        else             view = state_q;
    end

    assign count_o = view;

    updn_term u_term (
        .value_i (view),
        .dir_i   (dir_i),
        .en_n_i  (en_n_i),
        .tc_n_o  (tc_n_o)
    );
endmodule

// File: rtl/updn_chain.sv
module updn_chain
    import updn_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic                        clk,
    input  logic                        clr_i,
    input  logic                        load_i,
    input  logic                        up_i,
    input  logic                        en_n_i,
    input  logic [SLICE_W*STAGES-1:0]   data_i,
    output logic [SLICE_W*STAGES-1:0]   count_o,
    output logic                        tc_n_o
);
    localparam int TOTAL_W = SLICE_W * STAGES;

    dir_e              dir;
    logic [STAGES:0]   ripple_n;

    assign dir         = up_i ? DIR_UP : DIR_DOWN;
    assign ripple_n[0] = en_n_i;

    for (genvar k = 0; k < STAGES; k++) begin : g_slice
        updn_slice u_slice (
            .clk     (clk),
            .clr_i   (clr_i),
            .load_i  (load_i),
            .dir_i   (dir),
            .en_n_i  (ripple_n[k]),
            .data_i  (data_i[k*SLICE_W +: SLICE_W]),
            .count_o (count_o[k*SLICE_W +: SLICE_W]),
            .tc_n_o  (ripple_n[k+1])
        );
    end

    assign tc_n_o = ripple_n[STAGES];
endmodule

// File: rtl/updn_chain_chk.sv
module updn_chain_chk #(
    parameter int TOTAL_W = 8
) (
    input logic               clk,
    input logic               clr_i,
    input logic               load_i,
    input logic               up_i,
    input logic               en_n_i,
    input logic [TOTAL_W-1:0] data_i,
    input logic [TOTAL_W-1:0] count_o,
    input logic               tc_n_o
);
    always @(negedge clk) begin
        if (clr_i) begin
            AST_CLEAR_ZERO: assert (count_o == '0); // R1
        end
    end

    AST_LOAD_FOLLOW: assert property (@(posedge clk) disable iff (clr_i)
        load_i |-> count_o == data_i); // R2

    AST_LOAD_KEEP: assert property (@(posedge clk) disable iff (clr_i)
        ($fell(load_i) && !$past(clr_i)) |-> count_o == $past(data_i)); // R3

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (clr_i)
        (!$past(clr_i) && !$past(load_i) && $past(en_n_i) && !load_i) |-> $stable(count_o)); // R4

    AST_STEP_UP: assert property (@(posedge clk) disable iff (clr_i)
        (!$past(clr_i) && !$past(load_i) && !$past(en_n_i) && $past(up_i) && !load_i)
        |-> count_o == TOTAL_W'($past(count_o) + 1'b1)); // R5

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (clr_i)
        (!$past(clr_i) && !$past(load_i) && !$past(en_n_i) && !$past(up_i) && !load_i)
        |-> count_o == TOTAL_W'($past(count_o) - 1'b1)); // R6

    AST_TC_TOP: assert property (@(posedge clk) disable iff (clr_i)
        (!tc_n_o && up_i) |-> (count_o == '1 && !en_n_i)); // R7

    AST_TC_BOTTOM: assert property (@(posedge clk) disable iff (clr_i)
        (!tc_n_o && !up_i) |-> (count_o == '0 && !en_n_i)); // R8
endmodule

bind updn_chain updn_chain_chk #(.TOTAL_W(TOTAL_W)) u_chk (
    .clk     (clk),
    .clr_i   (clr_i),
    .load_i  (load_i),
    .up_i    (up_i),
    .en_n_i  (en_n_i),
    .data_i  (data_i),
    .count_o (count_o),
    .tc_n_o  (tc_n_o)
);

// File: tb/updn_chain_bench.sv
`timescale 1ns/1ps
module updn_chain_bench;
    localparam int STAGES = 2;
    localparam int W = 4 * STAGES;

    logic         clk = 1'b0;
    logic         clr_i = 1'b1;
    logic         load_i = 1'b0;
    logic         up_i = 1'b1;
    logic         en_n_i = 1'b1;
    logic [W-1:0] data_i = '0;
    logic [W-1:0] count_o;
    logic         tc_n_o;

    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    updn_chain #(.STAGES(STAGES)) u_updn_chain (
        .clk(clk), .clr_i(clr_i), .load_i(load_i), .up_i(up_i),
        .en_n_i(en_n_i), .data_i(data_i), .count_o(count_o), .tc_n_o(tc_n_o)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_load(input logic [W-1:0] v);
        load_i = 1'b1;
        data_i = v;
        step();
        load_i = 1'b0;
        data_i = ~v;
        #1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1;
        chk("R1 reset count", count_o, 8'h00);
        chk("R7 reset tc (enable off)", W'(tc_n_o), W'(1'b1));
        load_i = 1'b1; data_i = 8'hA5; #1;
        chk("R1 clear overrides load", count_o, 8'h00);
        step();
        chk("R1 clear held across edge", count_o, 8'h00);
        load_i = 1'b0; clr_i = 1'b0; #1;
    endtask

    task automatic t_load();
        load_i = 1'b1; data_i = 8'h3C; #1;
        chk("R2 load pass-through", count_o, 8'h3C);
        data_i = 8'h5A; #1;
        chk("R2 load follows data", count_o, 8'h5A);
        step();
        load_i = 1'b0; data_i = 8'h00; #1;
        chk("R3 value kept after load", count_o, 8'h5A);
    endtask

    task automatic t_hold();
        en_n_i = 1'b1; up_i = 1'b1;
        repeat (3) step();
        chk("R4 hold with enable off", count_o, 8'h5A);
        up_i = 1'b0; step();
        chk("R4 hold in down direction", count_o, 8'h5A);
    endtask

    task automatic t_up();
        up_i = 1'b1; en_n_i = 1'b0;
        step(); chk("R5 up step 1", count_o, 8'h5B);
        step(); chk("R5 up step 2", count_o, 8'h5C);
        do_load(8'h0F);
        step(); chk("R9 carry between slices", count_o, 8'h10);
        do_load(8'hFE);
        chk("R7 tc high below top", W'(tc_n_o), W'(1'b1));
        step(); chk("R5 up to top", count_o, 8'hFF);
        chk("R7 tc low at top", W'(tc_n_o), W'(1'b0));
        step(); chk("R5 wrap to zero", count_o, 8'h00);
        chk("R7 tc high after wrap", W'(tc_n_o), W'(1'b1));
    endtask

    task automatic t_down();
        up_i = 1'b0; en_n_i = 1'b0;
        do_load(8'h01);
        chk("R8 tc high above bottom", W'(tc_n_o), W'(1'b1));
        step(); chk("R6 down to zero", count_o, 8'h00);
        chk("R8 tc low at zero", W'(tc_n_o), W'(1'b0));
        en_n_i = 1'b1; #1;
        chk("R8 tc follows enable", W'(tc_n_o), W'(1'b1));
        en_n_i = 1'b0; up_i = 1'b1; #1;
        chk("R8 tc follows direction", W'(tc_n_o), W'(1'b1));
        up_i = 1'b0; #1;
        step(); chk("R6 wrap to all ones", count_o, 8'hFF);
        up_i = 1'b1;
        step(); chk("R5 turn back up at wrap", count_o, 8'h00);
        up_i = 1'b0;
        do_load(8'h10);
        step(); chk("R9 borrow between slices", count_o, 8'h0F);
    endtask

    task automatic t_clear_mid();
        up_i = 1'b1; en_n_i = 1'b0;
        do_load(8'h40);
        step(); chk("R5 counting before clear", count_o, 8'h41);
        clr_i = 1'b1; #1;
        chk("R1 clear without edge", count_o, 8'h00);
        step();
        clr_i = 1'b0; #1;
        chk("R1 cleared state kept", count_o, 8'h00);
        step(); chk("R5 count resumes from zero", count_o, 8'h01);
        load_i = 1'b1; data_i = 8'h77; #1;
        step(); chk("R2 load mid-count", count_o, 8'h77);
        load_i = 1'b0; #1;
        step(); chk("R5 count after mid load", count_o, 8'h78);
    endtask

    initial begin : watchdog
        #100000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_load();
        t_hold();
        t_up();
        t_down();
        t_clear_mid();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule